// File: doc/BRIEF.md
# Packed Equal-Any Compare Unit

This block is the execution slice of a 32-bit processor that handles the equal-any compare operations. Each cycle it takes a 32-bit instruction word and the values of the two source registers. It decodes the word as one of four operations:

- byte compare, register form
- half-word compare, register form
- byte compare, immediate form
- half-word compare, immediate form

The unit splits the first operand into lanes, either four bytes or two half-words. It compares each lane with the lane in the same position of the second operand. In immediate form the second operand is a 9-bit constant from the instruction, sign-extended to the full word before the lanes are split. The lane results are ORed together. The unit writes 32'h1 when any lane matches and zero when none does.

The compare is combinational and is followed by one registered output stage. The registered outputs are the destination register index, the 32-bit result, a valid flag for a recognised encoding, and an illegal flag for any other word. An illegal word always produces a zero result. Register-file reads, write-back and pipeline control are handled by the surrounding core.

Top module: `eqany_unit`

## Requirements
- R1: In byte mode the result is 32'h1 when any of bytes [31:24], [23:16], [15:8], [7:0] of src_a equals the byte at the same position of operand B, else 32'h0.
- R2: In half-word mode the result is 32'h1 when src_a[31:16] equals operand B[31:16] or src_a[15:0] equals operand B[15:0], else 32'h0; byte matches that do not form a whole half-word match give 32'h0.
- R3: Bits [31:1] of the result are zero in every cycle.
- R4: In immediate form operand B is instr[20:12] sign-extended to 32 bits; a constant with bit 8 set gives 8'hFF / 16'hFFFF in the upper lanes.
- R5: Immediate form is recognised when instr[7:0] = 8'h8B; instr[27:21] = 7'h56 selects byte mode and 7'h76 half-word mode.
- R6: Register form is recognised when instr[7:0] = 8'h0B; instr[27:20] = 8'h56 selects byte mode and the parameter HALF_OP_RR (default 8'h76) half-word mode; operand B is src_b.
- R7: In register form, instr[19:16] has no effect on any output.
- R8: Any word matching none of the four encodings sets op_illegal, clears rd_valid and gives rd_data = 0; a recognised word sets rd_valid and clears op_illegal.
- R9: All outputs appear one clock after the inputs are presented, and rd_idx equals instr[31:28] of that word.
- R10: While rst_n is low at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction word to decode |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value (register form) |
| rd_idx | output | 4 | Destination register index |
| rd_data | output | 32 | Result: 32'h1 or 32'h0 |
| rd_valid | output | 1 | Recognised encoding |
| op_illegal | output | 1 | Unrecognised encoding |

## Verification
The assertions check on every cycle that:
- only bit 0 of the result can be set;
- the valid and illegal flags never both rise;
- an illegal word yields a zero result;
- the destination index follows the instruction word by one clock;
- the immediate operand carries the constant's sign into all upper bits.

The following can only be shown by the bench's scenarios, which compare against a lane-by-lane reference model:
- that the right lanes are compared in each width mode;
- that a byte match inside an unequal half-word does not count;
- that negative constants fill the upper lanes;
- that the exact opcode values are decoded;
- that bits [19:16] of a register-form word are ignored.

// File: rtl/eqany_pkg.sv
// Package: shared encodings and types of the equal-any compare unit.
// Assumes a 32-bit instruction word with the primary opcode in bits [7:0].
package eqany_pkg;

    localparam int INSTR_W = 32;
    localparam int IMM_W   = 9;
    localparam int IDX_W   = 4;

    localparam logic [7:0] PRI_IMM      = 8'h8B;
    localparam logic [7:0] PRI_REG      = 8'h0B;
    localparam logic [6:0] SEC_IMM_BYTE = 7'h56;
    localparam logic [6:0] SEC_IMM_HALF = 7'h76;
    localparam logic [7:0] SEC_REG_BYTE = 8'h56;

    // Lane width selected by the decoded operation
    typedef enum logic [1:0] {
        LW_NONE = 2'd0,
        LW_BYTE = 2'd1,
        LW_HALF = 2'd2
    } lane_mode_e;

    // Decoded view of one instruction word
    typedef struct packed {
        logic       legal;
        logic       use_imm;
        lane_mode_e mode;
        logic [3:0] dst;
    } dec_info_s;

endpackage

// File: rtl/eqany_decode.sv
// Module: eqany_decode
// Recognises the four equal-any encodings and forms operand B. Operand B is
// src_b in register form and the sign-extended 9-bit constant in immediate form.
// Assumes DATA_W >= IMM_W. Bits [19:16] of a register-form word are not examined.
module eqany_decode
    import eqany_pkg::*;
#(
    parameter int         DATA_W     = 32,
    parameter logic [7:0] HALF_OP_RR = 8'h76
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0] src_b,
    output dec_info_s         info,
    output logic [DATA_W-1:0] opnd_b
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [7:0]       pri;
    logic [6:0]       sec_imm;
    logic [7:0]       sec_reg;
    logic [IMM_W-1:0] konst;
    logic [DATA_W-1:0] imm_ext;

    // Split the word into its fields
    always_comb begin
        pri     = instr[7:0];
        sec_imm = instr[27:21];
        sec_reg = instr[27:20];
        konst   = instr[20:12];
        imm_ext = {{EXT_W{konst[IMM_W-1]}}, konst};
    end

    // Classify the word into format and lane width
    always_comb begin
        info.legal   = 1'b0;
        info.use_imm = 1'b0;
        info.mode    = LW_NONE;
        info.dst     = instr[31:28];
        if (pri == PRI_IMM) begin
            info.use_imm = 1'b1;
            if (sec_imm == SEC_IMM_BYTE) begin
                info.legal = 1'b1;
                info.mode  = LW_BYTE;
            end else if (sec_imm == SEC_IMM_HALF) begin
                info.legal = 1'b1;
                info.mode  = LW_HALF;
            end
        end else if (pri == PRI_REG) begin
            if (sec_reg == SEC_REG_BYTE) begin
                info.legal = 1'b1;
                info.mode  = LW_BYTE;
            end else if (sec_reg == HALF_OP_RR) begin
                info.legal = 1'b1;
                info.mode  = LW_HALF;
            end
        end
    end

    // Choose the second operand by format
    always_comb begin
        opnd_b = info.use_imm ? imm_ext : src_b;
    end

    // R4: the constant's sign reaches every upper bit of operand B
    p_imm_sign_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[7:0] == PRI_IMM && instr[20]) |-> (&opnd_b[DATA_W-1:IMM_W-1]));

endmodule

// File: rtl/eqany_lanes.sv
// Module: eqany_lanes
// Compares DATA_W/LANE_W lanes of two operands position by position and
// reports whether any lane pair is equal. Assumes LANE_W divides DATA_W.
module eqany_lanes #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              any_eq
);

    localparam int N_LANES = DATA_W / LANE_W;

    logic [N_LANES-1:0] lane_eq;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        // One equality comparator per lane
        always_comb begin
            lane_eq[g] = (opa[g*LANE_W +: LANE_W] == opb[g*LANE_W +: LANE_W]);
        end
    end

    // Reduce the per-lane results to one flag
    always_comb begin
        any_eq = |lane_eq;
    end

endmodule

// File: rtl/eqany_unit.sv
// Module: eqany_unit (top)
// Single-cycle equal-any compare: decode, lane compare in byte and half-word
// widths, mode select, then one registered output stage with a synchronous
// active-low reset. Assumes a new instruction word may be presented each cycle.
module eqany_unit
    import eqany_pkg::*;
#(
    parameter int         DATA_W     = 32,
    parameter logic [7:0] HALF_OP_RR = 8'h76
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [3:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              op_illegal
);

    localparam int N_WIDTHS = 2;

    dec_info_s           info;
    logic [DATA_W-1:0]   opnd_b;
    logic [N_WIDTHS-1:0] width_hit;
    logic                hit;

    eqany_decode #(
        .DATA_W    (DATA_W),
        .HALF_OP_RR(HALF_OP_RR)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .instr (instr),
        .src_b (src_b),
        .info  (info),
        .opnd_b(opnd_b)
    );

    // Index 0 compares bytes, index 1 compares half-words
    for (genvar w = 0; w < N_WIDTHS; w++) begin : g_width
        eqany_lanes #(
            .DATA_W(DATA_W),
            .LANE_W(8 << w)
        ) u_lanes (
            .opa   (src_a),
            .opb   (opnd_b),
            .any_eq(width_hit[w])
        );
    end

    // Pick the lane-width result named by the decoded mode
    always_comb begin
        unique case (info.mode)
            LW_BYTE: hit = width_hit[0];
            LW_HALF: hit = width_hit[1];
            default: hit = 1'b0;
        endcase
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx     <= '0;
            rd_data    <= '0;
            rd_valid   <= 1'b0;
            op_illegal <= 1'b0;
        end else begin
            rd_idx     <= info.dst;
            rd_data    <= {{(DATA_W-1){1'b0}}, hit & info.legal};
            rd_valid   <= info.legal;
            op_illegal <= ~info.legal;
        end
    end

    // R3: nothing above bit 0 is ever written
    p_upper_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:1] == '0);

    // R8: an illegal word never leaves a result behind
    p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |-> (rd_data == '0 && !rd_valid));

    // R8: valid and illegal are never raised together
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && op_illegal));

    // R9: the destination index trails the instruction word by one clock
    p_dest_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rd_idx == $past(instr[31:28]));

endmodule

// File: tb/sim_eqany_unit.sv
// Bench for eqany_unit: a behavioural lane-by-lane reference model feeds a
// queue of expectations that is compared against the outputs every clock.
module sim_eqany_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [3:0]  rd_idx;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        op_illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [3:0]  idx;
        logic [31:0] data;
        logic        valid;
        logic        illegal;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    eqany_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr     (instr),
        .src_a     (src_a),
        .src_b     (src_b),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .op_illegal(op_illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] enc_imm(input logic [3:0] d, input logic [6:0] s,
                                            input logic [8:0] k, input logic [3:0] a);
        return {d, s, k, a, 8'h8B};
    endfunction

    function automatic logic [31:0] enc_reg(input logic [3:0] d, input logic [7:0] s,
                                            input logic [3:0] junk, input logic [3:0] b,
                                            input logic [3:0] a);
        return {d, s, junk, b, a, 8'h0B};
    endfunction

    // Behavioural model: returns expectation for one word
    function automatic exp_t model(input logic [31:0] w, input logic [31:0] a,
                                   input logic [31:0] b, input string tag);
        exp_t e;
        int lane = 0;
        int any  = 0;
        logic [31:0] opb;
        e.tag = tag;
        e.idx = w[31:28];
        opb   = b;
        if (w[7:0] == 8'h8B) begin
            opb = {{23{w[20]}}, w[20:12]};
            if (w[27:21] == 7'h56) lane = 8;
            if (w[27:21] == 7'h76) lane = 16;
        end else if (w[7:0] == 8'h0B) begin
            if (w[27:20] == 8'h56) lane = 8;
            if (w[27:20] == 8'h76) lane = 16;
        end
        if (lane != 0) begin
            for (int k = 0; k < 32 / lane; k++) begin
                logic [31:0] msk = (lane == 8) ? 32'hFF : 32'hFFFF;
                if (((a >> (k*lane)) & msk) == ((opb >> (k*lane)) & msk)) any = 1;
            end
        end
        e.valid   = (lane != 0);
        e.illegal = (lane == 0);
        e.data    = (any != 0) ? 32'h1 : 32'h0;
        return e;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Drive one word at a falling edge, compare at the next falling edge
    task automatic step(input logic [31:0] w, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
        exp_t e;
        instr = w;
        src_a = a;
        src_b = b;
        exp_q.push_back(model(w, a, b, tag));
        @(negedge clk);
        e = exp_q.pop_front();
        chk(e.tag, "rd_data", rd_data, e.data);
        chk(e.tag, "rd_valid", {31'b0, rd_valid}, {31'b0, e.valid});
        chk(e.tag, "op_illegal", {31'b0, op_illegal}, {31'b0, e.illegal});
        chk("R9", "rd_idx", {28'b0, rd_idx}, {28'b0, e.idx});
        chk("R3", "upper bits", {1'b0, rd_data[31:1]}, 32'h0);
    endtask

    // Expect a specific result value, independent of the model
    task automatic step_lit(input logic [31:0] w, input logic [31:0] a,
                            input logic [31:0] b, input logic [31:0] want,
                            input string tag);
        step(w, a, b, tag);
        chk(tag, "literal rd_data", rd_data, want);
    endtask

    initial begin
        logic [31:0] r_a, r_b, r_w;
        logic [31:0] keep;
        repeat (3) @(negedge clk);
        // R10: held in reset
        chk("R10", "rd_data", rd_data, 32'h0);
        chk("R10", "flags", {30'b0, rd_valid, op_illegal}, 32'h0);
        chk("R10", "rd_idx", {28'b0, rd_idx}, 32'h0);
        rst_n = 1'b1;

        // R1 R6: register byte, one lane equal, then none equal
        step_lit(enc_reg(4'h3, 8'h56, 4'h0, 4'h2, 4'h1), 32'h11223344, 32'hAA22BBCC, 32'h1, "R1");
        step_lit(enc_reg(4'h5, 8'h56, 4'h0, 4'h2, 4'h1), 32'h11223344, 32'h44332211, 32'h0, "R1");
        step_lit(enc_reg(4'h6, 8'h56, 4'h0, 4'h2, 4'h1), 32'h000000FE, 32'h123456FE, 32'h1, "R6");
        // R2: half-word equal, and byte-only match that must not count
        step_lit(enc_reg(4'h7, 8'h76, 4'h0, 4'h2, 4'h1), 32'hDEAD5678, 32'hBEEF5678, 32'h1, "R2");
        step_lit(enc_reg(4'h8, 8'h76, 4'h0, 4'h2, 4'h1), 32'h12345678, 32'h12995578, 32'h0, "R2");
        step_lit(enc_reg(4'h8, 8'h56, 4'h0, 4'h2, 4'h1), 32'h12345678, 32'h12995578, 32'h1, "R1");
        // R4 R5: immediate forms with negative and positive constants
        step_lit(enc_imm(4'h9, 7'h56, 9'h1FF, 4'h1), 32'h00FF0000, 32'h0, 32'h1, "R4");
        step_lit(enc_imm(4'hA, 7'h76, 9'h1FF, 4'h1), 32'h0000FFFF, 32'h0, 32'h1, "R4");
        step_lit(enc_imm(4'hB, 7'h76, 9'h1FF, 4'h1), 32'h00FF00FF, 32'h0, 32'h0, "R4");
        step_lit(enc_imm(4'hC, 7'h56, 9'h100, 4'h1), 32'h12FF3400, 32'hFFFFFFFF, 32'h1, "R4");
        step_lit(enc_imm(4'hD, 7'h56, 9'h0AB, 4'h1), 32'h12000034, 32'h0, 32'h1, "R5");
        step_lit(enc_imm(4'hE, 7'h56, 9'h0AB, 4'h1), 32'h12131415, 32'h0, 32'h0, "R5");
        step_lit(enc_imm(4'hF, 7'h76, 9'h0AB, 4'h1), 32'h777700AB, 32'h0, 32'h1, "R5");
        // R7: bits [19:16] change nothing in register form
        for (int j = 0; j < 16; j++) begin
            step_lit(enc_reg(4'h4, 8'h76, j[3:0], 4'h2, 4'h1), 32'hCAFE0001, 32'hCAFE0002, 32'h1, "R7");
            chk("R7", "valid with junk", {31'b0, rd_valid}, 32'h1);
        end
        // R8: unknown encodings
        step_lit(enc_reg(4'h2, 8'h57, 4'h0, 4'h2, 4'h1), 32'h5, 32'h5, 32'h0, "R8");
        step_lit(enc_imm(4'h2, 7'h57, 9'h005, 4'h1), 32'h5, 32'h5, 32'h0, "R8");
        step_lit({4'h2, 7'h56, 9'h005, 4'h1, 8'h8A}, 32'h5, 32'h5, 32'h0, "R8");
        chk("R8", "illegal flag", {31'b0, op_illegal}, 32'h1);
        step_lit(enc_reg(4'h2, 8'hAC, 4'h0, 4'h2, 4'h1), 32'h5, 32'h5, 32'h0, "R8");
        // R9: back-to-back words with changing destinations
        step(enc_imm(4'h1, 7'h56, 9'h001, 4'h0), 32'h01, 32'h0, "R9");
        step(enc_imm(4'hE, 7'h76, 9'h001, 4'h0), 32'h01, 32'h0, "R9");
        // Mixed random traffic
        for (int n = 0; n < 400; n++) begin
            r_a = $urandom;
            r_b = $urandom;
            if (n % 3 == 0) r_b = {r_a[31:8], r_b[7:0]};
            if (n % 5 == 0) r_b = {r_b[31:16], r_a[15:0]};
            case (n % 6)
                0: r_w = enc_reg($urandom, 8'h56, $urandom, 4'h2, 4'h1);
                1: r_w = enc_reg($urandom, 8'h76, $urandom, 4'h2, 4'h1);
                2: r_w = enc_imm($urandom, 7'h56, $urandom, 4'h1);
                3: r_w = enc_imm($urandom, 7'h76, $urandom, 4'h1);
                4: begin
                    keep = $urandom;
                    r_w  = enc_imm(keep[3:0], 7'h76, {keep[31], 8'h0}, 4'h1);
                    r_a  = keep[31] ? 32'hFFFF0000 : 32'h0000FFFF;
                end
                default: r_w = $urandom;
            endcase
            step(r_w, r_a, r_b, (n % 6 < 2) ? "R6" : (n % 6 < 5) ? "R5" : "R8");
        end
        // R10: reset again clears outputs
        step(enc_reg(4'h9, 8'h56, 4'h0, 4'h2, 4'h1), 32'h1, 32'h1, "R1");
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10", "rd_data after reset", rd_data, 32'h0);
        chk("R10", "rd_idx after reset", {28'b0, rd_idx}, 32'h0);
        chk("R10", "flags after reset", {30'b0, rd_valid, op_illegal}, 32'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule